// File: doc/BRIEF.md
# Big-Endian Port-Space Window Bridge

This block sits on a CPU's physical memory bus and claims one aligned 64 KB address window. A load or store that lands in the window becomes a single cycle on a 16-bit port-addressed I/O bus. The port address is the low half of the CPU address. The transfer width (byte, halfword or word) is carried across unchanged. The devices behind the ports and any arbitration between masters lie outside the block.

The CPU is big-endian and the port bus is little-endian, so the bridge reorders bytes when the `cfg_big_endian` input is high. Halfword and word data is byte-reversed on writes going out and on reads coming back. Single bytes are never reordered. With `cfg_big_endian` low, all sizes pass straight through. In every mode, lanes above the transfer size are driven as zero.

The CPU holds `cpu_req` and its qualifiers until it sees `cpu_ready`. The port side holds `io_rd` or `io_wr` until the device raises `io_ack`. The CPU sees `cpu_ready` one cycle after that acknowledge.

Top module: `isa_io_bridge`

## Requirements
- R1: `cpu_hit` is high exactly when `cpu_req` is high and `cpu_addr` lies in 0x14000000..0x1400FFFF inclusive.
- R2: A request whose address lies outside the window starts no port cycle (`io_rd`, `io_wr` stay low) and never raises `cpu_ready`.
- R3: `io_addr` equals `cpu_addr[15:0]` of the accepted request and stays constant for the whole port cycle.
- R4: Size encoding on `cpu_size` and `io_size`: 0 = byte, 1 = halfword, 2 = word. For byte accesses, in either mode, `io_wdata` = {24'h0, `cpu_wdata[7:0]`}, and read data returns as {24'h0, `io_rdata[7:0]`}.
- R5: With `cfg_big_endian` = 1, halfword writes drive {16'h0, wdata[7:0], wdata[15:8]}, and halfword reads return {16'h0, rdata[7:0], rdata[15:8]}.
- R6: With `cfg_big_endian` = 1, word accesses reverse all four bytes in both directions.
- R7: With `cfg_big_endian` = 0, halfword and word data pass unchanged in both directions; halfword upper lanes are zero.
- R8: The strobe (`io_rd` for reads, `io_wr` for writes) rises the cycle after an in-window request with a legal size is seen in idle. It stays high until the clock edge that samples `io_ack`. The other strobe stays low. `io_size` equals `cpu_size`.
- R9: `cpu_ready` is high for exactly one cycle, the cycle after the edge that samples `io_ack`. `cpu_rdata` holds its value during that cycle and after it until the next read completes.
- R10: An in-window request with `cpu_size` = 3 starts no port cycle. The cycle after it is seen, `cpu_ready` and `cpu_err` are both high for one cycle. `cpu_err` is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_big_endian | input | 1 | 1 = reorder multi-byte data between CPU and port bus |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word, 3 illegal |
| cpu_addr | input | 32 | CPU physical address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_hit | output | 1 | Request falls inside the window |
| cpu_ready | output | 1 | One-cycle access completion |
| cpu_err | output | 1 | Completion with illegal size |
| cpu_rdata | output | 32 | Read data, in CPU byte order |
| io_addr | output | 16 | Port address |
| io_size | output | 2 | Port transfer size |
| io_wdata | output | 32 | Port write data, in port byte order |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| io_ack | input | 1 | Port cycle acknowledge |
| io_rdata | input | 32 | Port read data |

## Verification
The bridge keeps its state in a sequencer and a set of captured request fields. A corrupted sequencer state shows at the ports within one cycle: a strobe with no request, a ready pulse lasting two cycles, or no ready after an acknowledge. A wrongly captured size or byte-order flag shows only when the data is examined, as a lane pattern that is reversed or shifted. Byte, halfword and word transfers therefore use distinct bytes in every lane, in both modes. The window edges and the illegal size are exercised separately, because a decode error shows only at those addresses.

// File: rtl/isa_io_bridge_pkg.sv
package isa_io_bridge_pkg;
  typedef enum logic [1:0] {
    XS_BYTE = 2'd0,
    XS_HALF = 2'd1,
    XS_WORD = 2'd2,
    XS_BAD  = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_DONE = 2'd2,
    ST_FAIL = 2'd3
  } bridge_state_e;
endpackage

// File: rtl/isa_window_decode.sv
module isa_window_decode #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h1400_0000,
  parameter int WIN_LOG2 = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          size,
  output logic                hit,
  output logic                size_ok,
  output logic [WIN_LOG2-1:0] port_addr
);
  import isa_io_bridge_pkg::*;

  localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + ({{ADDR_W{1'b0}}, 1'b1} << WIN_LOG2);

  logic tag_match;

  // Window base is aligned to its own size, so only the upper bits decide.
  assign tag_match = (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
  assign hit       = req && tag_match;
  assign size_ok   = (size != XS_BAD);
  assign port_addr = addr[WIN_LOG2-1:0];

  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ({1'b0, addr} >= {1'b0, WIN_BASE} && {1'b0, addr} < WIN_END)); // R1
  AST_RANGE_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req && {1'b0, addr} >= {1'b0, WIN_BASE} && {1'b0, addr} < WIN_END) |-> hit); // R1
endmodule

// File: rtl/isa_lane_order.sv
module isa_lane_order #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size,
  input  logic              big_endian,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int NBYTES = DATA_W / 8;

  // Keep the lanes the size covers and reverse them if asked; zero the rest.
  function automatic logic [DATA_W-1:0] order_lanes(input logic [1:0] sz,
                                                    input logic be,
                                                    input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    int nb;
    nb = 1 << sz;
    if (nb > NBYTES) nb = NBYTES;
    r = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (i < nb) begin
        if (be) r[8*i +: 8] = d[8*(nb-1-i) +: 8];
        else    r[8*i +: 8] = d[8*i +: 8];
      end
    end
    return r;
  endfunction

  assign dout = order_lanes(size, big_endian, din);
endmodule

// File: rtl/isa_io_bridge.sv
module isa_io_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h1400_0000,
  parameter int WIN_LOG2 = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_big_endian,
  input  logic                cpu_req,
  input  logic                cpu_wr,
  input  logic [1:0]          cpu_size,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic                cpu_hit,
  output logic                cpu_ready,
  output logic                cpu_err,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic [WIN_LOG2-1:0] io_addr,
  output logic [1:0]          io_size,
  output logic [DATA_W-1:0]   io_wdata,
  output logic                io_rd,
  output logic                io_wr,
  input  logic                io_ack,
  input  logic [DATA_W-1:0]   io_rdata
);
  import isa_io_bridge_pkg::*;

  bridge_state_e       state_q, state_d;
  logic                dec_hit, dec_size_ok;
  logic [WIN_LOG2-1:0] dec_port;
  logic                wr_q, be_q;
  logic [DATA_W-1:0]   out_lanes, in_lanes;

  // Named events for the assertions
  logic ev_accept, ev_reject, ev_ack_taken;

  isa_window_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)) u_dec (
    .clk(clk), .rst_n(rst_n), .req(cpu_req), .addr(cpu_addr), .size(cpu_size),
    .hit(dec_hit), .size_ok(dec_size_ok), .port_addr(dec_port)
  );

  isa_lane_order #(.DATA_W(DATA_W)) u_wr_order (
    .size(cpu_size), .big_endian(cfg_big_endian), .din(cpu_wdata), .dout(out_lanes)
  );

  isa_lane_order #(.DATA_W(DATA_W)) u_rd_order (
    .size(io_size), .big_endian(be_q), .din(io_rdata), .dout(in_lanes)
  );

  assign ev_accept    = (state_q == ST_IDLE) && dec_hit && dec_size_ok;
  assign ev_reject    = (state_q == ST_IDLE) && dec_hit && !dec_size_ok;
  assign ev_ack_taken = (state_q == ST_BUS) && io_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ev_accept)      state_d = ST_BUS;
        else if (ev_reject) state_d = ST_FAIL;
      end
      ST_BUS:  if (io_ack) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      ST_FAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_q      <= 1'b0;
      be_q      <= 1'b0;
      io_addr   <= '0;
      io_size   <= XS_BYTE;
      io_wdata  <= '0;
      cpu_rdata <= '0;
    end else begin
      state_q <= state_d;
      if (ev_accept) begin
        wr_q     <= cpu_wr;
        be_q     <= cfg_big_endian;
        io_addr  <= dec_port;
        io_size  <= cpu_size;
        io_wdata <= out_lanes;
      end
      if (ev_ack_taken && !wr_q) cpu_rdata <= in_lanes;
    end
  end

  assign cpu_hit   = dec_hit;
  assign io_rd     = (state_q == ST_BUS) && !wr_q;
  assign io_wr     = (state_q == ST_BUS) && wr_q;
  assign cpu_ready = (state_q == ST_DONE) || (state_q == ST_FAIL);
  assign cpu_err   = (state_q == ST_FAIL);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_wr)); // R8
  AST_STROBE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_rd || io_wr) |-> $past(cpu_hit)); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd || io_wr) && !io_ack) |=> $stable(io_addr) && (io_rd || io_wr)); // R3
  AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd || io_wr) && io_ack) |=> cpu_ready && !cpu_err); // R9
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready); // R9
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> $stable(cpu_rdata)); // R9
  AST_ERR_NO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> (cpu_ready && !io_rd && !io_wr)); // R10
endmodule

// File: tb/isa_io_bridge_tb.sv
module isa_io_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big_endian = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_hit, cpu_ready, cpu_err;
  logic [31:0] cpu_rdata;
  logic [15:0] io_addr;
  logic [1:0]  io_size;
  logic [31:0] io_wdata;
  logic        io_rd, io_wr;
  logic        io_ack = 1'b0;
  logic [31:0] io_rdata = '0;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  isa_io_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_hit(cpu_hit), .cpu_ready(cpu_ready), .cpu_err(cpu_err),
    .cpu_rdata(cpu_rdata), .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_ack(io_ack), .io_rdata(io_rdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected byte arrangement, written out per size rather than looped
  function automatic logic [31:0] arrange(input logic [1:0] sz, input logic be, input logic [31:0] d);
    case (sz)
      2'd0: return {24'h0, d[7:0]};
      2'd1: return be ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
      default: return be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    endcase
  endfunction

  // One in-window access with a port responder that waits lat extra cycles
  task automatic do_access(input string rq, input logic be, input logic w, input logic [1:0] sz,
                           input logic [31:0] a, input logic [31:0] wd, input logic [31:0] prd,
                           input int lat);
    logic [31:0] exp_rd;
    @(negedge clk);
    cfg_big_endian = be; cpu_req = 1; cpu_wr = w; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
    #1;
    chk("R1", "hit in window", {31'b0, cpu_hit}, 32'd1);
    @(negedge clk);
    chk("R8", "read strobe", {31'b0, io_rd}, {31'b0, !w});
    chk("R8", "write strobe", {31'b0, io_wr}, {31'b0, w});
    chk("R8", "port size", {30'b0, io_size}, {30'b0, sz});
    chk("R3", "port address", {16'b0, io_addr}, {16'b0, a[15:0]});
    if (w) chk(rq, "port write data", io_wdata, arrange(sz, be, wd));
    for (int i = 0; i < lat; i++) begin
      chk("R9", "no early ready", {31'b0, cpu_ready}, 32'd0);
      @(negedge clk);
      chk("R8", "strobe held", {31'b0, io_rd | io_wr}, 32'd1);
      chk("R3", "address held", {16'b0, io_addr}, {16'b0, a[15:0]});
    end
    io_ack = 1; io_rdata = prd;
    @(negedge clk);
    io_ack = 0; io_rdata = 32'hDEAD_BEEF;
    chk("R9", "ready after ack", {31'b0, cpu_ready}, 32'd1);
    chk("R10", "no error on legal size", {31'b0, cpu_err}, 32'd0);
    chk("R8", "strobe dropped", {31'b0, io_rd | io_wr}, 32'd0);
    exp_rd = arrange(sz, be, prd);
    if (!w) chk(rq, "cpu read data", cpu_rdata, exp_rd);
    cpu_req = 0;
    @(negedge clk);
    chk("R9", "ready one cycle", {31'b0, cpu_ready}, 32'd0);
    if (!w) chk("R9", "read data held", cpu_rdata, exp_rd);
  endtask

  task automatic miss_case(input logic [31:0] a);
    @(negedge clk);
    cpu_req = 1; cpu_wr = 0; cpu_size = 2'd2; cpu_addr = a;
    #1;
    chk("R1", "no hit outside", {31'b0, cpu_hit}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2", "no port cycle outside", {30'b0, io_rd, io_wr}, 32'd0);
      chk("R2", "no ready outside", {31'b0, cpu_ready}, 32'd0);
    end
    cpu_req = 0;
  endtask

  task automatic bad_size_case();
    @(negedge clk);
    cpu_req = 1; cpu_wr = 1; cpu_size = 2'd3; cpu_addr = 32'h1400_0010; cpu_wdata = 32'h1122_3344;
    @(negedge clk);
    chk("R10", "error ready", {30'b0, cpu_ready, cpu_err}, 32'd3);
    chk("R10", "no port cycle", {30'b0, io_rd, io_wr}, 32'd0);
    cpu_req = 0;
    @(negedge clk);
    chk("R10", "error one cycle", {30'b0, cpu_ready, cpu_err}, 32'd0);
    chk("R10", "still no port cycle", {30'b0, io_rd, io_wr}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "reset ready", {31'b0, cpu_ready}, 32'd0);
    chk("R8", "reset strobes", {30'b0, io_rd, io_wr}, 32'd0);
    chk("R10", "reset error", {31'b0, cpu_err}, 32'd0);
    rst_n = 1;
    // R4 byte in both modes
    do_access("R4", 1, 1, 2'd0, 32'h1400_0060, 32'hAABB_CC5A, 32'h0, 0);
    do_access("R4", 1, 0, 2'd0, 32'h1400_03F8, 32'h0, 32'h1234_56C3, 1);
    do_access("R4", 0, 0, 2'd0, 32'h1400_0201, 32'h0, 32'hFFEE_DD7E, 0);
    // R5 big-endian halfword
    do_access("R5", 1, 1, 2'd1, 32'h1400_0300, 32'h9988_1234, 32'h0, 2);
    do_access("R5", 1, 0, 2'd1, 32'h1400_1002, 32'h0, 32'h5566_A1B2, 0);
    // R6 big-endian word
    do_access("R6", 1, 1, 2'd2, 32'h1400_ABCC, 32'h0102_0304, 32'h0, 0);
    do_access("R6", 1, 0, 2'd2, 32'h1400_0004, 32'h0, 32'hC0DE_F00D, 3);
    // R7 little-endian pass-through
    do_access("R7", 0, 1, 2'd1, 32'h1400_0020, 32'hFFFF_8421, 32'h0, 0);
    do_access("R7", 0, 0, 2'd2, 32'h1400_0040, 32'h0, 32'h8765_4321, 1);
    do_access("R7", 0, 1, 2'd2, 32'h1400_0044, 32'hA5B6_C7D8, 32'h0, 0);
    // window edges (R1, R3)
    do_access("R6", 1, 0, 2'd2, 32'h1400_0000, 32'h0, 32'h0A0B_0C0D, 0);
    do_access("R5", 1, 0, 2'd1, 32'h1400_FFFE, 32'h0, 32'h0000_7F80, 0);
    miss_case(32'h13FF_FFFF);
    miss_case(32'h1401_0000);
    miss_case(32'h0000_0060);
    bad_size_case();
    do_access("R6", 1, 0, 2'd2, 32'h1400_0100, 32'h0, 32'h1357_9BDF, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule